// File: doc/BRIEF.md
# MSK Transmit Bit Sequencer

This block is the digital heart of a 2400 bit/s MSK transmitter. From a 3.579545 MHz master clock it derives a 2400 Hz bit clock, drives it onto a TCLK pin for an external data source, and samples the serial transmit bit on every rising edge of that clock. Each captured bit chooses the tone for the following bit period: a one is sent at 1200 Hz and a zero at 2400 Hz. The tone comes out as signed 12-bit sine samples, and its phase carries on without a jump across bit boundaries.

Two control bits steer the transmit path. The enable-low bit (`tde_i`) parks TCLK high and freezes the sequencer while it is 1. The path bit (`txafsw_i`) picks between voice, mute and MSK through a two-bit select code. After the enable bit returns to 1, a completion timer waits at least 2 ms so that the last bit can leave the modulator, and then it raises a flag. Software uses that flag before it switches the path back to voice.

Top module: `msk_tx_seq`

## Requirements
- R1: While `tde_i` is 1, `tclk_o` stays at 1 on every cycle.
- R2: While `tde_i` is 0, `tclk_o` is a square wave whose rise-to-rise spacing is 1491 or 1492 master clocks. This is 2400 Hz, produced by a 32-bit fractional accumulator.
- R3: The first rising edge of `tclk_o` after `tde_i` falls comes three quarters of a bit period later. This is between 746 and 1492 master clocks.
- R4: `tdata_i` is captured at the master clock edge on which `tclk_o` rises. The captured bit sets the tone for the following bit period: 1 gives 1200 Hz and 0 gives 2400 Hz. Eight bits of ones therefore show 8±1 sign changes, eight zeros show 16±1, and alternating bits show 12±1.
- R5: The tone phase is held at zero while `tde_i` is 1. While `tde_i` is 0 it advances by exactly one tone increment per clock, with no reset at bit boundaries. The first MSK sample after `tde_i` falls is therefore +31.
- R6: `tx_sel_o` is 2'b00 (voice) for `txafsw_i`=0 and `tde_i`=1. It is 2'b01 (mute) for `txafsw_i`=1 and `tde_i`=1, and also for both bits at 0. It is 2'b10 (MSK) for `txafsw_i`=1 and `tde_i`=0.
- R7: `msk_sample_o` is 0 whenever `tx_sel_o` is not MSK. In MSK it is a two's-complement sine sample that is never 0. The quarter-wave entry i (0..63) equals floor(2047·(2i+1)·(255−2i)/16384), so the peak magnitude is at most 2047 and at least 1900.
- R8: `tx_done_o` rises 7160 master clocks (at least 2 ms) after `tde_i` becomes 1. It stays 1 while `tde_i` stays 1.
- R9: `tx_done_o` drops on the first clock after `tde_i` is seen at 0. When `tde_i` returns to 1, the full 7160-cycle count starts again.
- R10: During reset `tclk_o` is 1 and `tx_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 3.579545 MHz master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tde_i | input | 1 | 1 parks the bit clock and ends MSK; 0 runs MSK |
| txafsw_i | input | 1 | Transmit path bit (1 leaves voice) |
| tdata_i | input | 1 | Serial transmit bit, sampled on TCLK rise |
| tclk_o | output | 1 | 2400 Hz bit clock, high while parked |
| msk_sample_o | output | 12 | Signed MSK tone sample |
| tx_sel_o | output | 2 | Path select: 00 voice, 01 mute, 10 MSK |
| tx_done_o | output | 1 | MSK tail time has elapsed |

## Verification
The assertions watch several properties on every cycle. They check that the captured bit changes only on a TCLK rise and equals the data present at that edge. They check that the tone phase steps by exactly one of the two increments while the sequencer runs, and that it sits at zero while parked. They also check that the done flag clears and holds in step with the enable bit. Some properties only the directed scenarios can show, because each spans a whole bit period or more: the 2400 Hz TCLK period, where the first edge falls after enabling, the tone frequency chosen by each bit pattern, the peak amplitude, and the exact length of the 2 ms tail window.

// File: rtl/msk_tx_pkg.sv
package msk_tx_pkg;

  typedef enum logic [1:0] {
    SEL_VOICE = 2'b00,
    SEL_MUTE  = 2'b01,
    SEL_MSK   = 2'b10
  } tx_sel_e;

  // round(hz / clk * 2^w)
  function automatic logic [63:0] phase_inc(input longint unsigned hz,
                                            input longint unsigned clk,
                                            input int w);
    return ((hz << w) + clk / 2) / clk;
  endfunction

  // parabolic quarter-wave, sampled at half steps
  function automatic int quarter_val(input int i, input int n, input int amp);
    longint num;
    num = longint'(amp) * longint'(2 * i + 1) * longint'(4 * n - 1 - 2 * i);
    return int'(num / longint'(4 * n * n));
  endfunction

endpackage

// File: rtl/msk_bitclk.sv
module msk_bitclk #(
  parameter int unsigned CLK_HZ = 3579545,
  parameter int unsigned BIT_HZ = 2400,
  parameter int          ACC_W  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tde_i,
  input  logic tdata_i,
  output logic tclk_o,
  output logic bit_o
);
  localparam logic [63:0] INC64 = msk_tx_pkg::phase_inc(BIT_HZ, CLK_HZ, ACC_W);
  localparam logic [ACC_W-1:0] INC  = INC64[ACC_W-1:0];
  // parked in high half; first rise 3/4 period after release
  localparam logic [ACC_W-1:0] PARK = {2'b11, {(ACC_W-2){1'b0}}};

  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic             bit_q, stb;

  assign acc_nxt = acc_q + INC;
  assign stb     = !tde_i && !acc_q[ACC_W-1] && acc_nxt[ACC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= PARK;
    else if (tde_i) acc_q <= PARK;
    else            acc_q <= acc_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bit_q <= 1'b1;
    else if (stb) bit_q <= tdata_i;
  end

  assign tclk_o = tde_i | acc_q[ACC_W-1];
  assign bit_o  = bit_q;

  a_r4_capture_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tde_i && !$past(tde_i) && tclk_o && !$past(tclk_o)) |-> bit_q == $past(tdata_i));

  a_r4_bit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tclk_o && !$past(tclk_o)) |-> $stable(bit_q));

endmodule

// File: rtl/msk_tone_gen.sv
module msk_tone_gen #(
  parameter int unsigned CLK_HZ   = 3579545,
  parameter int unsigned MARK_HZ  = 1200,
  parameter int unsigned SPACE_HZ = 2400,
  parameter int          PH_W     = 32,
  parameter int          TBL_AW   = 6,
  parameter int          SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tde_i,
  input  logic                bit_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int TBL_N = 1 << TBL_AW;
  localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;
  localparam logic [63:0] MARK64  = msk_tx_pkg::phase_inc(MARK_HZ, CLK_HZ, PH_W);
  localparam logic [63:0] SPACE64 = msk_tx_pkg::phase_inc(SPACE_HZ, CLK_HZ, PH_W);
  localparam logic [PH_W-1:0] INC_MARK  = MARK64[PH_W-1:0];
  localparam logic [PH_W-1:0] INC_SPACE = SPACE64[PH_W-1:0];

  logic [SAMPLE_W-1:0] qtab [TBL_N];

  for (genvar g = 0; g < TBL_N; g++) begin : g_tab
    localparam int QV = msk_tx_pkg::quarter_val(g, TBL_N, AMP);
    assign qtab[g] = SAMPLE_W'(QV);
  end

  logic [PH_W-1:0]     ph_q;
  logic [1:0]          quad;
  logic [TBL_AW-1:0]   idx, addr;
  logic [SAMPLE_W-1:0] mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ph_q <= '0;
    else if (tde_i) ph_q <= '0;
    else            ph_q <= ph_q + (bit_i ? INC_MARK : INC_SPACE);
  end

  assign quad = ph_q[PH_W-1 -: 2];
  assign idx  = ph_q[PH_W-3 -: TBL_AW];
  assign addr = quad[0] ? ~idx : idx;
  assign mag  = qtab[addr];
  assign sample_o = quad[1] ? (~mag + 1'b1) : mag;

  a_r5_phase_continuous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tde_i && !$past(tde_i)) |->
      ((ph_q - $past(ph_q)) == INC_MARK || (ph_q - $past(ph_q)) == INC_SPACE));

  a_r5_phase_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tde_i) |-> ph_q == '0);

endmodule

// File: rtl/msk_done_timer.sv
module msk_done_timer #(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned TAIL_US = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tde_i,
  output logic done_o
);
  localparam longint unsigned TAIL_CYC =
    (longint'(CLK_HZ) * longint'(TAIL_US) + 64'd999999) / 64'd1000000;
  localparam int CNT_W = $clog2(TAIL_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TAIL_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!tde_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  a_r9_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tde_i |=> !done_o);

  a_r8_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && tde_i) |=> done_o);

endmodule

// File: rtl/msk_tx_seq.sv
module msk_tx_seq #(
  parameter int unsigned CLK_HZ   = 3579545,
  parameter int unsigned BIT_HZ   = 2400,
  parameter int unsigned MARK_HZ  = 1200,
  parameter int unsigned SPACE_HZ = 2400,
  parameter int unsigned TAIL_US  = 2000,
  parameter int          ACC_W    = 32,
  parameter int          TBL_AW   = 6,
  parameter int          SAMPLE_W = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tde_i,
  input  logic                       txafsw_i,
  input  logic                       tdata_i,
  output logic                       tclk_o,
  output logic signed [SAMPLE_W-1:0] msk_sample_o,
  output logic [1:0]                 tx_sel_o,
  output logic                       tx_done_o
);
  import msk_tx_pkg::*;

  logic                cur_bit;
  logic [SAMPLE_W-1:0] tone;
  tx_sel_e             sel;

  msk_bitclk #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .ACC_W(ACC_W)) u_bitclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .tde_i(tde_i), .tdata_i(tdata_i),
    .tclk_o(tclk_o), .bit_o(cur_bit)
  );

  msk_tone_gen #(
    .CLK_HZ(CLK_HZ), .MARK_HZ(MARK_HZ), .SPACE_HZ(SPACE_HZ),
    .PH_W(ACC_W), .TBL_AW(TBL_AW), .SAMPLE_W(SAMPLE_W)
  ) u_tone (
    .clk_i(clk_i), .rst_ni(rst_ni), .tde_i(tde_i), .bit_i(cur_bit),
    .sample_o(tone)
  );

  msk_done_timer #(.CLK_HZ(CLK_HZ), .TAIL_US(TAIL_US)) u_done (
    .clk_i(clk_i), .rst_ni(rst_ni), .tde_i(tde_i), .done_o(tx_done_o)
  );

  always_comb begin
    case ({txafsw_i, tde_i})
      2'b01:   sel = SEL_VOICE;
      2'b10:   sel = SEL_MSK;
      default: sel = SEL_MUTE;
    endcase
  end

  assign tx_sel_o     = sel;
  assign msk_sample_o = (sel == SEL_MSK) ? $signed(tone) : '0;

  a_r1_tclk_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tde_i) && tde_i) |-> tclk_o);

  a_r7_sample_nonzero_msk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sel_o == SEL_MSK) |-> msk_sample_o != '0);

endmodule

// File: tb/msk_tx_seq_test.sv
module msk_tx_seq_test;
  localparam time CLK_PERIOD = 280ns;
  localparam int  WDOG_CYC   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tde = 1'b1, txafsw = 1'b0, tdata = 1'b0;
  logic tclk, done;
  logic signed [11:0] smp;
  logic [1:0] sel;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  msk_tx_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .tde_i(tde), .txafsw_i(txafsw),
    .tdata_i(tdata), .tclk_o(tclk), .msk_sample_o(smp),
    .tx_sel_o(sel), .tx_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_neg(3);
    chk(tclk == 1'b1, "R10 tclk in reset", int'(tclk), 1);
    chk(done == 1'b0, "R10 done in reset", int'(done), 0);
    chk(sel == 2'b00, "R6 voice code", int'(sel), 0);
    chk(smp == 0, "R7 sample zero in voice", int'(smp), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_done_window(input string tag);
    wait_neg(7100);
    chk(done == 1'b0, {tag, " R8 done early"}, int'(done), 0);
    wait_neg(70);
    chk(done == 1'b1, {tag, " R8 done after window"}, int'(done), 1);
  endtask

  task automatic t_park;
    int bad = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (tclk !== 1'b1) bad++;
    end
    chk(bad == 0, "R1 tclk parked high", bad, 0);
    chk(done == 1'b1, "R8 done held", int'(done), 1);
  endtask

  task automatic t_select;
    txafsw = 1'b1; tde = 1'b1; @(negedge clk);
    chk(sel == 2'b01, "R6 mute code", int'(sel), 1);
    chk(smp == 0, "R7 sample zero in mute", int'(smp), 0);
    tde = 1'b0; @(negedge clk);
    chk(sel == 2'b10, "R6 msk code", int'(sel), 2);
    chk(done == 1'b0, "R9 done cleared", int'(done), 1'b0);
    txafsw = 1'b0; @(negedge clk);
    chk(sel == 2'b01, "R6 both low mute", int'(sel), 1);
    chk(smp == 0, "R7 sample zero both low", int'(smp), 0);
    tde = 1'b1; @(negedge clk);
    chk(sel == 2'b00, "R6 voice again", int'(sel), 0);
    wait_neg(100);
    tde = 1'b0; wait_neg(5);
    tde = 1'b1;
    // count restarts from the last rise of tde
    wait_neg(7100);
    chk(done == 1'b0, "R9 restart count", int'(done), 0);
    wait_neg(70);
    chk(done == 1'b1, "R9 done after restart", int'(done), 1);
  endtask

  task automatic t_first_rise;
    int n = 0, prev, gap;
    txafsw = 1'b1; tde = 1'b1; wait_neg(4);
    tde = 1'b0; @(negedge clk);
    chk(smp == 31, "R5 phase restarts at zero", int'(smp), 31);
    prev = tclk;
    n = 1;
    while (!(tclk == 1'b1 && prev == 0)) begin
      prev = tclk; @(negedge clk); n++;
    end
    chk(n >= 746 && n <= 1492, "R3 first tclk rise", n, 1119);
    for (int k = 0; k < 3; k++) begin
      gap = 0; prev = tclk;
      do begin prev = tclk; @(negedge clk); gap++; end
      while (!(tclk == 1'b1 && prev == 0));
      chk(gap == 1491 || gap == 1492, "R2 tclk period", gap, 1491);
    end
    tde = 1'b1; wait_neg(4);
  endtask

  task automatic t_tone(input logic [7:0] pat, input int lo, input int hi, input string tag);
    int rises = 0, xings = 0, zeros = 0, peak = 0, prev_t, a;
    logic prev_s;
    txafsw = 1'b1; tde = 1'b1; wait_neg(4);
    tdata = pat[0];
    tde = 1'b0; @(negedge clk);
    prev_t = tclk;
    while (rises < 9) begin
      @(negedge clk);
      if (rises > 0) begin
        if (smp[11] != prev_s) xings++;
        if (smp == 0) zeros++;
        a = smp < 0 ? -int'(smp) : int'(smp);
        if (a > peak) peak = a;
      end
      prev_s = smp[11];
      if (tclk == 1'b1 && prev_t == 0) begin
        rises++;
        if (rises < 8) tdata = pat[rises];
      end
      prev_t = tclk;
    end
    chk(xings >= lo && xings <= hi, {"R4 tone ", tag}, xings, (lo + hi) / 2);
    chk(zeros == 0, {"R7 no zero sample ", tag}, zeros, 0);
    chk(peak >= 1900 && peak <= 2047, {"R7 peak ", tag}, peak, 2046);
    tde = 1'b1; wait_neg(4);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WDOG_CYC) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG_CYC);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_done_window("after reset");
    t_park();
    t_select();
    t_first_rise();
    t_tone(8'hFF, 7, 9, "ones");
    t_tone(8'h00, 15, 17, "zeros");
    t_tone(8'h55, 11, 13, "alternating");
    t_done_window("after msk");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule